// File: doc/BRIEF.md
# SAR ADC Conversion Controller

This block is the digital side of a 12-bit successive-approximation converter. A host (or a single strobe line, in stand-alone use) drives a chip select, a combined read/convert line and a high-byte select. A falling read/convert edge, accepted only when the block is idle and both selects are low, launches a conversion. The block then works through the twelve bit decisions, most significant first. For each decision it presents a trial code to the analog array and reads back one comparator bit. When the last decision is made, the code goes into a result latch and the block returns to tracking the input. One cycle after that, the busy flag rises again.

The tri-state data bus is modelled as a data vector plus a per-line output-enable vector. The result is driven only while read/convert is high, the block is not converting and chip select is low. The high-byte select chooses between the full 12-bit word and a byte-wide transfer of the top four bits. While a conversion runs, every control input is locked out, so a conversion can be neither restarted nor cut short. The read/convert line passes through a two-flop synchroniser before its edges are detected.

Top module: `adc_sar_ctl`

## Requirements
- R1: A conversion is started only by a high-to-low transition of the synchronised rd_conv. Steady levels and rising edges start nothing.
- R2: A falling rd_conv edge is ignored if cs_n is high or hi_byte is high in the cycle the edge is detected.
- R3: busy_n stays low for exactly 12*CYC_PER_BIT+1 cycles per conversion. It rises one cycle after the result latch is written.
- R4: While busy_n is low, changes on rd_conv, cs_n and hi_byte neither restart nor shorten the conversion.
- R5: While busy_n is low, data_oe is all zeros.
- R6: data_oe is non-zero only when the synchronised rd_conv is high, busy_n is high and cs_n is low. Any line whose enable bit is 0 carries data_out 0.
- R7: With hi_byte low, all 12 lines are driven with the result (data_oe = 0xFFF). Lines [7:0] carry the 8 least significant bits.
- R8: With hi_byte high, only lines [7:0] are driven (data_oe = 0x0FF). Lines [7:4] carry result bits [11:8] and lines [3:0] are 0.
- R9: Each conversion is successive approximation, MSB first, and the first trial_code is 0x800. A cmp_in of 1 keeps the trial bit and 0 clears it, before the next lower bit is set. The latched result is the largest code not above the sensed input.
- R10: track is low while bit decisions run. It goes high in the cycle the result is latched, one cycle before busy_n rises.
- R11: busy_n falls after the third rising clock edge that samples rd_conv low, because of the two synchroniser flops and the edge-detect register.
- R12: After reset, busy_n is high, track is high, data_oe is zero and the latched result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_conv | input | 1 | Read (high) / convert (falling edge) control |
| hi_byte | input | 1 | Byte-lane select: 1 puts the top nibble on the low byte lane |
| cmp_in | input | 1 | Comparator decision: 1 when the input is at or above trial_code |
| trial_code | output | 12 | Code under trial, presented to the analog array |
| track | output | 1 | High while the front end follows the input |
| busy_n | output | 1 | Low during a conversion |
| data_out | output | 12 | Data bus value |
| data_oe | output | 12 | Per-line drive enable; 0 means high impedance |

## Verification
The bench builds the block with CYC_PER_BIT = 3, a 12-bit word and an 8-bit byte lane. A bit period that is not a power of two exercises the wrap of the decision counter away from a natural boundary. It also stretches the busy window to 37 cycles, which leaves room for a long burst of rd_conv, cs_n and hi_byte toggles inside one conversion. Analog inputs of 0, full scale and mixed patterns drive every bit decision both ways.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CONV = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_sar_rcsync.sv
module adc_sar_rcsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic level,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
    prev_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign level = chain_q[STAGES-1];
  assign fall  = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_sar_pkg::*;
#(
  parameter int NBITS       = 12,
  parameter int CYC_PER_BIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmp_in,
  output logic [NBITS-1:0] trial_code,
  output logic [NBITS-1:0] result,
  output logic             busy_n,
  output logic             track
);
  localparam int CW = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(CYC_PER_BIT - 1);
  localparam logic [NBITS-1:0] MSB_MASK = {1'b1, {(NBITS-1){1'b0}}};

  seq_state_e       state_q, state_d;
  logic [NBITS-1:0] sar_q, sar_d;
  logic [NBITS-1:0] bit_q, bit_d;
  logic [NBITS-1:0] res_q, res_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic [NBITS-1:0] decided;

  always_comb begin
    state_d = state_q;
    sar_d   = sar_q;
    bit_d   = bit_q;
    res_d   = res_q;
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    decided = cmp_in ? sar_q : (sar_q & ~bit_q);
    case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d = SEQ_CONV;
          sar_d   = MSB_MASK;
          bit_d   = MSB_MASK;
          cnt_d   = '0;
          busy_d  = 1'b0;
        end
      end
      SEQ_CONV: begin
        if (cnt_q == CNT_LAST) begin
          cnt_d = '0;
          if (bit_q[0]) begin
            sar_d   = decided;
            res_d   = decided;
            state_d = SEQ_DONE;
          end else begin
            bit_d = bit_q >> 1;
            sar_d = decided | (bit_q >> 1);
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_DONE: begin
        busy_d  = 1'b1;
        state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      sar_q   <= '0;
      bit_q   <= '0;
      res_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      sar_q   <= sar_d;
      bit_q   <= bit_d;
      res_q   <= res_d;
      cnt_q   <= cnt_d;
      busy_q  <= busy_d;
    end
  end

  assign trial_code = sar_q;
  assign result     = res_q;
  assign busy_n     = busy_q;
  assign track      = (state_q != SEQ_CONV);
endmodule

// File: rtl/adc_sar_busdrv.sv
module adc_sar_busdrv #(
  parameter int NBITS  = 12,
  parameter int BYTE_W = 8
) (
  input  logic [NBITS-1:0] result,
  input  logic             rc_level,
  input  logic             busy_n,
  input  logic             cs_n,
  input  logic             hi_byte,
  output logic [NBITS-1:0] data_out,
  output logic [NBITS-1:0] data_oe
);
  localparam int HI_W  = NBITS - BYTE_W;
  localparam int PAD_W = BYTE_W - HI_W;

  logic             drive;
  logic [BYTE_W-1:0] hi_lane;

  assign drive   = rc_level & busy_n & ~cs_n;
  assign hi_lane = {result[NBITS-1:BYTE_W], {PAD_W{1'b0}}};

  always_comb begin
    data_out = '0;
    data_oe  = '0;
    if (drive) begin
      if (hi_byte) begin
        data_oe[BYTE_W-1:0]  = '1;
        data_out[BYTE_W-1:0] = hi_lane;
      end else begin
        data_oe  = '1;
        data_out = result;
      end
    end
  end
endmodule

// File: rtl/adc_sar_ctl.sv
module adc_sar_ctl #(
  parameter int NBITS       = 12,
  parameter int BYTE_W      = 8,
  parameter int CYC_PER_BIT = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_conv,
  input  logic             hi_byte,
  input  logic             cmp_in,
  output logic [NBITS-1:0] trial_code,
  output logic             track,
  output logic             busy_n,
  output logic [NBITS-1:0] data_out,
  output logic [NBITS-1:0] data_oe
);
  logic             rc_level;
  logic             rc_fall;
  logic             start_ok;
  logic [NBITS-1:0] result;

  adc_sar_rcsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rd_conv),
    .level (rc_level),
    .fall  (rc_fall)
  );

  assign start_ok = rc_fall & ~cs_n & ~hi_byte & busy_n;

  adc_sar_seq #(.NBITS(NBITS), .CYC_PER_BIT(CYC_PER_BIT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_ok),
    .cmp_in     (cmp_in),
    .trial_code (trial_code),
    .result     (result),
    .busy_n     (busy_n),
    .track      (track)
  );

  adc_sar_busdrv #(.NBITS(NBITS), .BYTE_W(BYTE_W)) u_bus (
    .result   (result),
    .rc_level (rc_level),
    .busy_n   (busy_n),
    .cs_n     (cs_n),
    .hi_byte  (hi_byte),
    .data_out (data_out),
    .data_oe  (data_oe)
  );
endmodule

// File: rtl/adc_sar_chk.sv
module adc_sar_chk #(
  parameter int NBITS  = 12,
  parameter int BYTE_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             hi_byte,
  input logic             busy_n,
  input logic             track,
  input logic [NBITS-1:0] data_out,
  input logic [NBITS-1:0] data_oe
);
  localparam int PAD_W = BYTE_W - (NBITS - BYTE_W);

  // R5
  hiz_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> (data_oe == '0));

  // R6
  hiz_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (data_oe == '0));

  // R2
  start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> $past(!cs_n && !hi_byte));

  // R10
  track_leads_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(track) |=> $rose(busy_n));

  // R8
  low_nibble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_byte && data_oe != '0) |-> (data_out[PAD_W-1:0] == '0));
endmodule

bind adc_sar_ctl adc_sar_chk #(.NBITS(NBITS), .BYTE_W(BYTE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .hi_byte  (hi_byte),
  .busy_n   (busy_n),
  .track    (track),
  .data_out (data_out),
  .data_oe  (data_oe)
);

// File: tb/adc_sar_ctl_test.sv
module adc_sar_ctl_test;
  localparam int C = 3;
  localparam int CONV_LEN = 12 * C + 1;

  logic        clk;
  logic        rst_n;
  logic        cs_n;
  logic        rd_conv;
  logic        hi_byte;
  logic        cmp_in;
  logic [11:0] trial_code;
  logic        track;
  logic        busy_n;
  logic [11:0] data_out;
  logic [11:0] data_oe;
  logic [11:0] vin;

  int total = 0;
  int bad   = 0;
  bit cmp_en = 0;
  bit done  = 0;

  adc_sar_ctl #(.NBITS(12), .BYTE_W(8), .CYC_PER_BIT(C), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_conv(rd_conv), .hi_byte(hi_byte),
    .cmp_in(cmp_in), .trial_code(trial_code), .track(track), .busy_n(busy_n),
    .data_out(data_out), .data_oe(data_oe)
  );

  assign cmp_in = (vin >= trial_code);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit          m_s1, m_s2, m_prev;
  int          m_left;
  logic [11:0] m_res;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_left = 0; m_res = '0;
    end else begin
      bit fl;
      bit go;
      fl = m_prev && !m_s2;
      go = fl && !cs_n && !hi_byte && (m_left == 0);
      m_prev = m_s2; m_s2 = m_s1; m_s1 = rd_conv;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 1) m_res = vin;
      end else if (go) begin
        m_left = CONV_LEN;
      end
    end
  end

  always begin
    @(negedge clk);
    #1;
    if (cmp_en && !done) begin
      logic [11:0] e_oe, e_dat;
      bit drv;
      drv   = m_s2 && (m_left == 0) && !cs_n;
      e_oe  = '0;
      e_dat = '0;
      if (drv) begin
        if (hi_byte) begin e_oe = 12'h0FF; e_dat = {4'h0, m_res[11:8], 4'h0}; end
        else begin e_oe = 12'hFFF; e_dat = m_res; end
      end
      chk(busy_n == (m_left == 0), "R3 busy_n per cycle", busy_n, (m_left == 0));
      chk(data_oe == e_oe, "R6 data_oe per cycle", data_oe, e_oe);
      chk(data_out == e_dat, "R7 data_out per cycle", data_out, e_dat);
      chk(track == (m_left <= 1), "R10 track per cycle", track, (m_left <= 1));
    end
  end

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000", wd);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_in(input logic rc, input logic cs, input logic hb);
    @(negedge clk);
    rd_conv = rc; cs_n = cs; hi_byte = hb;
  endtask

  // convert-mode pulse, then wait for completion
  task automatic convert(input logic [11:0] v);
    vin = v;
    set_in(1'b0, 1'b0, 1'b0);
    set_in(1'b1, 1'b0, 1'b0);
    wait_cyc(CONV_LEN + 6);
  endtask

  task automatic read_word(input logic hb, input logic [11:0] v, input string tag);
    set_in(1'b1, 1'b0, hb);
    wait_cyc(3);
    #1;
    if (hb) begin
      chk(data_oe == 12'h0FF, {tag, " R8 oe"}, data_oe, 12'h0FF);
      chk(data_out[7:0] == {v[11:8], 4'h0}, {tag, " R8 lane"}, data_out, {v[11:8], 4'h0});
    end else begin
      chk(data_oe == 12'hFFF, {tag, " R7 oe"}, data_oe, 12'hFFF);
      chk(data_out == v, {tag, " R9 word"}, data_out, v);
      chk(data_out[7:0] == v[7:0], {tag, " R7 low lane"}, data_out[7:0], v[7:0]);
    end
  endtask

  initial begin
    rst_n = 0; cs_n = 1; rd_conv = 1; hi_byte = 0; vin = '0;
    wait_cyc(3);
    #1;
    chk(busy_n == 1'b1, "R12 reset busy_n", busy_n, 1);
    chk(track == 1'b1, "R12 reset track", track, 1);
    chk(data_oe == '0, "R12 reset oe", data_oe, 0);
    @(negedge clk);
    rst_n = 1;
    cmp_en = 1;
    set_in(1'b1, 1'b0, 1'b0);
    wait_cyc(3);
    #1;
    chk(data_out == 12'h000 && data_oe == 12'hFFF, "R12 reset result", data_out, 0);

    // R11 latency of the start
    vin = 12'hA5C;
    set_in(1'b0, 1'b0, 1'b0);
    @(posedge clk); @(posedge clk); #1;
    chk(busy_n == 1'b1, "R11 not yet busy after two edges", busy_n, 1);
    @(posedge clk); #1;
    chk(busy_n == 1'b0, "R11 busy after third edge", busy_n, 0);
    chk(trial_code == 12'h800, "R9 first trial", trial_code, 12'h800);
    set_in(1'b1, 1'b0, 1'b0);
    wait_cyc(CONV_LEN + 4);
    read_word(1'b0, 12'hA5C, "A5C");
    read_word(1'b1, 12'hA5C, "A5C");

    // R2 suppressed starts
    set_in(1'b1, 1'b1, 1'b0);
    vin = 12'h123;
    set_in(1'b0, 1'b1, 1'b0);
    wait_cyc(6); #1;
    chk(busy_n == 1'b1, "R2 cs_n high blocks start", busy_n, 1);
    set_in(1'b1, 1'b0, 1'b1);
    wait_cyc(3);
    set_in(1'b0, 1'b0, 1'b1);
    wait_cyc(6); #1;
    chk(busy_n == 1'b1, "R2 hi_byte high blocks start", busy_n, 1);

    // R1 levels and rising edges start nothing
    set_in(1'b0, 1'b0, 1'b0);
    wait_cyc(6); #1;
    chk(busy_n == 1'b1, "R1 steady low no start", busy_n, 1);
    set_in(1'b1, 1'b0, 1'b0);
    wait_cyc(6); #1;
    chk(busy_n == 1'b1, "R1 rising edge no start", busy_n, 1);
    read_word(1'b0, 12'hA5C, "kept");

    // R4 lockout with toggling inputs, R3 busy length
    begin
      int n_low = 0;
      vin = 12'h3C7;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (i == 0) begin rd_conv = 0; cs_n = 0; hi_byte = 0; end
        else if (i >= 4 && i <= 30) begin rd_conv = i[0]; cs_n = i[1]; hi_byte = i[2]; end
        else if (i == 31) begin rd_conv = 1; cs_n = 0; hi_byte = 0; end
        #1;
        if (!busy_n) n_low++;
        if (!busy_n) chk(data_oe == '0, "R5 hiz while busy", data_oe, 0);
      end
      chk(n_low == CONV_LEN, "R4 R3 busy length under toggles", n_low, CONV_LEN);
    end
    read_word(1'b0, 12'h3C7, "3C7");

    // R10 track rises one cycle before busy_n
    vin = 12'h5A5;
    set_in(1'b0, 1'b0, 1'b0);
    set_in(1'b1, 1'b0, 1'b0);
    begin
      int guard = 0;
      while (track && guard < 10) begin @(negedge clk); #1; guard++; end
      guard = 0;
      while (!track && guard < 60) begin @(negedge clk); #1; guard++; end
      chk(busy_n == 1'b0, "R10 busy still low as track rises", busy_n, 0);
      @(negedge clk); #1;
      chk(busy_n == 1'b1, "R10 busy high next cycle", busy_n, 1);
    end
    read_word(1'b0, 12'h5A5, "5A5");

    // R9 extremes
    convert(12'h000);
    read_word(1'b0, 12'h000, "zero");
    convert(12'hFFF);
    read_word(1'b0, 12'hFFF, "full");
    read_word(1'b1, 12'hFFF, "full");

    // read mode: normally low, positive pulse reads then starts
    set_in(1'b0, 1'b0, 1'b0);
    wait_cyc(CONV_LEN + 6);
    vin = 12'h81E;
    set_in(1'b1, 1'b0, 1'b0);
    wait_cyc(3); #1;
    chk(data_out == 12'hFFF, "R6 read mode shows previous", data_out, 12'hFFF);
    set_in(1'b0, 1'b0, 1'b0);
    wait_cyc(4); #1;
    chk(busy_n == 1'b0, "R1 read-mode falling edge starts", busy_n, 0);
    wait_cyc(CONV_LEN + 2); #1;
    chk(data_oe == '0, "R6 rd_conv low no drive", data_oe, 0);
    read_word(1'b0, 12'h81E, "81E");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule